// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block paces the serial clock of an I2C master. A programmable baud count sets the clock period. A speed-mode selector picks the standard or fast duty split. The block drives the clock line low for the low phase and then releases it. While the clock is released, the high-phase counter only advances on cycles where the sampled clock line actually reads high. A slave that holds the clock low therefore stretches the high phase instead of shortening it.

The block also issues a one-cycle enable that tells the data-line logic when to change SDA. That enable is placed a programmable number of cycles ahead of the clock release, so that data setup is guaranteed. The low phase is lengthened if the requested setup is longer than the nominal low time. Three more single-cycle markers are produced: the start of each low phase, the first counted high cycle, and the data change point. A sequencer uses these markers to shift bits. The period settings are captured at the start of every clock period.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset the clock is released (`scl_low` = 0) and `tick_low`, `tick_high` and `tick_sda` are all 0.
- R2: While `run_en` is 0 the block is idle. From the cycle after `run_en` is sampled low, the clock is released and no tick is issued, even if the drop happens in the middle of a phase.
- R3: With `speed_mode` = 0 (standard), the low phase lasts B cycles and the high phase lasts B cycles, for a period of 2·B. B is the effective baud count.
- R4: With `speed_mode` = 1 (fast), the low phase lasts 2·B cycles and the high phase lasts B cycles, for a period of 3·B.
- R5: `speed_mode` values 2 and 3 are not supported and produce the standard timing of R3.
- R6: A baud count of 0 behaves as a baud count of 1, so every phase lasts at least one cycle.
- R7: With setup count S, `tick_sda` is high in exactly one low-phase cycle, and the clock is released exactly S+1 cycles after that cycle. S = 0 still gives one cycle. If S+1 exceeds the nominal low length, the low phase stretches to S+1 cycles and `tick_sda` falls in its first cycle.
- R8: In the high phase the counter advances only on cycles where `scl_in` is sampled 1. `tick_high` is asserted on the first such cycle. After that cycle, B−1 more released cycles follow before the next low phase. The clock stays released while a slave holds the line low.
- R9: `tick_low` is a single-cycle pulse in the first cycle of every low phase. Every rise of `scl_low` carries it.
- R10: The baud count, setup count and speed mode are captured when a low phase begins. Changing them during a period does not alter that period; the next period uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables clock generation; 0 holds the block idle |
| baud_cnt | input | BAUD_W (16) | Baud count for standard and fast rates |
| setup_cnt | input | SETUP_W (16) | Data setup count; setup lasts this value plus one cycle |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 and 3 fall back to standard |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| tick_low | output | 1 | First cycle of a low phase |
| tick_high | output | 1 | First counted high cycle |
| tick_sda | output | 1 | Cycle in which SDA may change |

## Verification
The assertions check several properties on every cycle. The idle state follows a low `run_en`. A rising clock-drive always carries the low tick. The low tick and SDA tick are single-cycle pulses that occur only while the clock is driven. The high tick only occurs on a sampled-high line. A held-low line in the high phase never lets the clock be driven again.

Phase lengths depend on the programmed counts, so only the bench's scenarios can show them. The bench sweeps baud counts, all four speed-mode codes and several setup counts, and measures the low length, high length and SDA tick position. Separate scenarios cover slave stretching, mid-phase disable and a configuration change in the middle of a period.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_FAST = 2'd1,
        SPD_HS   = 2'd2,
        SPD_FP   = 2'd3
    } speed_e;

    // Only the fast code selects the 2:1 low/high split; all others are standard.
    function automatic logic uses_fast_split(input logic [1:0] code);
        return speed_e'(code) == SPD_FAST;
    endfunction

endpackage

// File: rtl/scl_period_cfg.sv
module scl_period_cfg
    import scl_timing_pkg::*;
#(
    parameter int BAUD_W  = 16,
    parameter int SETUP_W = 16,
    parameter int CNT_W   = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [BAUD_W-1:0]  baud_cnt,
    input  logic [SETUP_W-1:0] setup_cnt,
    input  logic [1:0]         speed_mode,
    output logic [CNT_W-1:0]   low_last,
    output logic [CNT_W-1:0]   high_last,
    output logic [CNT_W-1:0]   sda_at
);

    logic [CNT_W-1:0] unit_len;
    logic [CNT_W-1:0] low_nom;
    logic [CNT_W-1:0] setup_len;
    logic [CNT_W-1:0] low_eff;

    always_comb begin
        unit_len  = (baud_cnt == '0) ? CNT_W'(1) : CNT_W'(baud_cnt);
        low_nom   = uses_fast_split(speed_mode) ? (unit_len << 1) : unit_len;
        setup_len = CNT_W'(setup_cnt) + CNT_W'(1);
        low_eff   = (setup_len > low_nom) ? setup_len : low_nom;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_last  <= '0;
            high_last <= '0;
            sda_at    <= '0;
        end else if (load) begin
            low_last  <= low_eff - CNT_W'(1);
            high_last <= unit_len - CNT_W'(1);
            sda_at    <= low_eff - setup_len;
        end
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] low_last,
    input  logic [CNT_W-1:0] high_last,
    output phase_e           st,
    output logic [CNT_W-1:0] cnt,
    output logic             load
);

    phase_e           st_n;
    logic [CNT_W-1:0] cnt_n;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        load  = 1'b0;
        if (!run_en) begin
            st_n  = PH_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st)
                PH_IDLE: begin
                    st_n  = PH_LOW;
                    cnt_n = '0;
                    load  = 1'b1;
                end
                PH_LOW: begin
                    if (cnt == low_last) begin
                        st_n  = PH_HIGH;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (scl_in) begin
                        if (cnt == high_last) begin
                            st_n  = PH_LOW;
                            cnt_n = '0;
                            load  = 1'b1;
                        end else begin
                            cnt_n = cnt + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    st_n  = PH_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

endmodule

// File: rtl/scl_tick_decode.sv
module scl_tick_decode
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  phase_e           st,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] sda_at,
    input  logic             scl_in,
    output logic             scl_low,
    output logic             tick_low,
    output logic             tick_high,
    output logic             tick_sda
);

    logic first_cnt;

    always_comb begin
        first_cnt = (cnt == '0);
        scl_low   = (st == PH_LOW);
        tick_low  = (st == PH_LOW) && first_cnt;
        tick_sda  = (st == PH_LOW) && (cnt == sda_at);
        tick_high = (st == PH_HIGH) && first_cnt && scl_in;
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int BAUD_W  = 16,
    parameter int SETUP_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_en,
    input  logic [BAUD_W-1:0]  baud_cnt,
    input  logic [SETUP_W-1:0] setup_cnt,
    input  logic [1:0]         speed_mode,
    input  logic               scl_in,
    output logic               scl_low,
    output logic               tick_low,
    output logic               tick_high,
    output logic               tick_sda
);

    localparam int WIDEST = (BAUD_W > SETUP_W) ? BAUD_W : SETUP_W;
    localparam int CNT_W  = WIDEST + 2;

    phase_e           st;
    logic [CNT_W-1:0] cnt;
    logic             load;
    logic [CNT_W-1:0] low_last;
    logic [CNT_W-1:0] high_last;
    logic [CNT_W-1:0] sda_at;

    scl_period_cfg #(
        .BAUD_W  (BAUD_W),
        .SETUP_W (SETUP_W),
        .CNT_W   (CNT_W)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .baud_cnt   (baud_cnt),
        .setup_cnt  (setup_cnt),
        .speed_mode (speed_mode),
        .low_last   (low_last),
        .high_last  (high_last),
        .sda_at     (sda_at)
    );

    scl_phase_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .scl_in    (scl_in),
        .low_last  (low_last),
        .high_last (high_last),
        .st        (st),
        .cnt       (cnt),
        .load      (load)
    );

    scl_tick_decode #(
        .CNT_W (CNT_W)
    ) u_dec (
        .st        (st),
        .cnt       (cnt),
        .sda_at    (sda_at),
        .scl_in    (scl_in),
        .scl_low   (scl_low),
        .tick_low  (tick_low),
        .tick_high (tick_high),
        .tick_sda  (tick_sda)
    );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk
    import scl_timing_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   run_en,
    input logic   scl_in,
    input logic   scl_low,
    input logic   tick_low,
    input logic   tick_high,
    input logic   tick_sda,
    input phase_e st
);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!scl_low && !tick_low && !tick_high && !tick_sda));

    assert_rise_has_tick_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_low) |-> tick_low);

    assert_tick_low_single_R9: assert property (@(posedge clk) disable iff (rst)
        tick_low |-> (scl_low ##1 !tick_low));

    assert_sda_in_low_R7: assert property (@(posedge clk) disable iff (rst)
        tick_sda |-> (scl_low ##1 !tick_sda));

    assert_high_tick_sampled_R8: assert property (@(posedge clk) disable iff (rst)
        tick_high |-> (scl_in && !scl_low));

    assert_stretch_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (st == PH_HIGH && !scl_in) |=> !scl_low);

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .scl_in    (scl_in),
    .scl_low   (scl_low),
    .tick_low  (tick_low),
    .tick_high (tick_high),
    .tick_sda  (tick_sda),
    .st        (st)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic [15:0] baud_cnt = 16'd1;
    logic [15:0] setup_cnt = 16'd0;
    logic [1:0]  speed_mode = 2'd0;
    logic        hold = 1'b0;
    logic        scl_in;
    logic        scl_low, tick_low, tick_high, tick_sda;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Open-drain line: low when the master drives or a slave holds it.
    assign scl_in = !scl_low && !hold;

    scl_timing_gen dut (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .baud_cnt   (baud_cnt),
        .setup_cnt  (setup_cnt),
        .speed_mode (speed_mode),
        .scl_in     (scl_in),
        .scl_low    (scl_low),
        .tick_low   (tick_low),
        .tick_high  (tick_high),
        .tick_sda   (tick_sda)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_tick_low();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (tick_low) return;
        end
    endtask

    // Called at a negedge where tick_low is seen; returns at the next one.
    task automatic measure(output int lo, output int hi, output int sda_pos,
                           output int sda_n, output int th_pos, output int th_n);
        lo = 0; hi = 0; sda_pos = -1; sda_n = 0; th_pos = -1; th_n = 0;
        while (scl_low && lo < 1000) begin
            if (tick_sda) begin sda_pos = lo; sda_n++; end
            lo++;
            @(negedge clk);
        end
        while (!scl_low && hi < 1000) begin
            if (tick_high) begin th_pos = hi; th_n++; end
            hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        int bauds[6] = '{0, 1, 2, 3, 5, 7};
        int setups[4] = '{0, 1, 3, 9};
        int lo, hi, sp, sn, tp, tn;
        repeat (3) @(negedge clk);
        check("R1", "scl_low in reset", int'(scl_low), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "ticks after reset", int'(tick_low | tick_high | tick_sda), 0);
        check("R2", "idle scl_low", int'(scl_low), 0);

        // Sweep of baud, speed code and setup count.
        for (int bi = 0; bi < 6; bi++) begin
            for (int m = 0; m < 4; m++) begin
                for (int si = 0; si < 4; si++) begin
                    int be, lnom, leff;
                    string tag;
                    be   = (bauds[bi] == 0) ? 1 : bauds[bi];
                    lnom = (m == 1) ? 2 * be : be;
                    leff = (setups[si] + 1 > lnom) ? setups[si] + 1 : lnom;
                    tag  = (m == 1) ? "R4" : ((m == 0) ? "R3" : "R5");
                    run_en = 1'b0;
                    repeat (2) @(negedge clk);
                    baud_cnt   = 16'(bauds[bi]);
                    setup_cnt  = 16'(setups[si]);
                    speed_mode = 2'(m);
                    run_en     = 1'b1;
                    wait_tick_low();
                    for (int p = 0; p < 2; p++) begin
                        measure(lo, hi, sp, sn, tp, tn);
                        check(tag, "low length", lo, leff);
                        check(tag, "high length", hi, be);
                        if (bauds[bi] == 0) check("R6", "low length baud 0", lo, leff);
                        check("R7", "sda tick position", sp, leff - (setups[si] + 1));
                        check("R7", "sda tick count", sn, 1);
                        check("R8", "high tick position", tp, 0);
                        check("R8", "high tick count", tn, 1);
                        check("R9", "tick_low at next period", int'(tick_low), 1);
                    end
                end
            end
        end

        // Slave stretching: line held low for 4 released cycles.
        run_en = 1'b0;
        repeat (2) @(negedge clk);
        baud_cnt = 16'd3; setup_cnt = 16'd0; speed_mode = 2'd0;
        hold = 1'b1;
        run_en = 1'b1;
        wait_tick_low();
        while (scl_low) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check("R8", "released while stretched", int'(scl_low), 0);
            check("R8", "no high tick while stretched", int'(tick_high), 0);
            if (k < 3) @(negedge clk);
        end
        hold = 1'b0;
        #1;
        check("R8", "high tick when line rises", int'(tick_high), 1);
        begin
            int rest = 0;
            @(negedge clk);
            while (!scl_low && rest < 100) begin rest++; @(negedge clk); end
            check("R8", "released cycles after rise", rest, 2);
            check("R9", "tick_low after stretch", int'(tick_low), 1);
        end

        // Drop run_en in the middle of a fast low phase.
        run_en = 1'b0;
        repeat (2) @(negedge clk);
        baud_cnt = 16'd6; speed_mode = 2'd1;
        run_en = 1'b1;
        wait_tick_low();
        repeat (3) @(negedge clk);
        run_en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R2", "released after disable", int'(scl_low), 0);
            check("R2", "no ticks after disable", int'(tick_low | tick_high | tick_sda), 0);
        end

        // Configuration change inside a period.
        baud_cnt = 16'd4; speed_mode = 2'd0; setup_cnt = 16'd0;
        run_en = 1'b1;
        wait_tick_low();
        baud_cnt = 16'd2;
        measure(lo, hi, sp, sn, tp, tn);
        check("R10", "current low unchanged", lo, 4);
        check("R10", "current high unchanged", hi, 4);
        measure(lo, hi, sp, sn, tp, tn);
        check("R10", "next low uses new baud", lo, 2);
        check("R10", "next high uses new baud", hi, 2);

        run_en = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule